// File: doc/BRIEF.md
# Static Memory Write Sequencer with Wait Freeze

This block turns single host write requests into timed write cycles on an external static memory bus. A request carries an address and a data word. The block drives them onto the bus and pulls the active-low chip select low. After a programmable number of setup cycles, it pulses the active-low write strobe for a programmable width. It then keeps chip select low for a programmable number of hold cycles before it releases it. The memory takes the data on the rising edge of the write strobe, and address and data stay valid across that edge.

The memory can stretch the cycle with an active-low wait line. The block passes that line through a two-stage synchronizer. While the synchronized wait is asserted inside the sampling window, the block freezes: its phase counter stops and every bus output keeps its value. When wait is released, the cycle continues from the point where it stopped. The sampling window is the strobe phase before its final cycle. A wait outside that window has no effect.

Top module: `sram_write_seq`

## Requirements
- R1: While reset is asserted and after it is released, `mem_cs_n` and `mem_we_n` are high and `req_done` is low until a request arrives.
- R2: A `req_start` pulse in idle makes `mem_cs_n` low from the next cycle. `mem_we_n` then stays high for exactly `cfg_setup` cycles (0 allowed) before it falls.
- R3: `mem_we_n` is low for exactly `cfg_strobe` consecutive cycles, and a value of 0 gives 1 cycle.
- R4: After `mem_we_n` rises, `mem_cs_n` stays low for exactly `cfg_hold` cycles (0 allowed), so chip select is low for setup + strobe + hold cycles.
- R5: Throughout the chip-select-low window, `mem_addr` and `mem_data` equal the address and data of the request.
- R6: `req_done` is high for exactly one cycle: the first cycle in which `mem_cs_n` is high again after a write.
- R7: `mem_wait_n` is synchronized by two flip-flops. A low level sampled at clock edges k through k+N-1 freezes edges k+2 through k+N+1. Each such freeze lengthens both the strobe and the chip-select window by one cycle.
- R8: While frozen, `mem_cs_n`, `mem_we_n`, `mem_addr` and `mem_data` do not change. After release, the remaining strobe cycles and all hold cycles still follow in full.
- R9: A freeze applies only at an edge where the strobe is low and is not in its last cycle. A wait during setup, during hold, or late in the strobe leaves the cycle timing unchanged.
- R10: `req_start` while a write is in progress is ignored: no second write and no second `req_done`.
- R11: Address, data and the configuration are captured when the request is accepted. Later changes of those inputs do not affect the write in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle write request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| cfg_setup | input | CNT_W | Cycles from chip select low to strobe low |
| cfg_strobe | input | CNT_W | Strobe low width in cycles (0 treated as 1) |
| cfg_hold | input | CNT_W | Cycles from strobe high to chip select high |
| req_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_data | output | DATA_W | Memory data bus |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_wait_n | input | 1 | Active-low wait from the memory, asynchronous |

## Verification
The assertions assume that `req_start` is a clean synchronous level, sampled only at rising edges. They also assume that `mem_wait_n`, although treated as asynchronous, has settled within a cycle so that the two-flop delay is exact. The bench changes every input on the falling clock edge, so each wait level is seen at a known rising edge. Each wait window is timed from the strobe start, so the expected lengthening can be worked out from R7 and R9. The ignored-start check drives start only while chip select is low, and the configuration changes are kept to that window as well.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/sws_wait_sync.sv
module sws_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign sync_n = chain_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk2
      // R7: assertion of the synchronized wait lags the pin by two edges
      a_r7_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_n) |-> ($past(pin_n, 2) == 1'b0));
    end
  endgenerate
endmodule

// File: rtl/sws_phase_cnt.sv
module sws_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                      cnt_d = load_val;
    else if (dec && cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

  // R3: a decrement step removes exactly one cycle from the phase
  a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !zero) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/sram_write_seq.sv
module sram_write_seq
  import sws_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_strobe,
  input  logic [CNT_W-1:0]  cfg_hold,
  output logic              req_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  input  logic              mem_wait_n
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  strb_q, hold_q;
  logic              done_q, done_d;
  logic              capture;
  logic              cnt_load, cnt_dec, cnt_zero;
  logic [CNT_W-1:0]  cnt_val, cnt_now;
  logic [CNT_W-1:0]  strb_eff;
  logic              wait_sync_n;
  logic              freeze;

  sws_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_n  (mem_wait_n),
    .sync_n (wait_sync_n)
  );

  sws_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .cnt      (cnt_now),
    .zero     (cnt_zero)
  );

  assign strb_eff = (cfg_strobe == '0) ? ONE : cfg_strobe;
  assign freeze   = (phase_q == PH_STROBE) && !wait_sync_n && !cnt_zero;

  always_comb begin
    phase_d  = phase_q;
    capture  = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    done_d   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_start) begin
          capture  = 1'b1;
          cnt_load = 1'b1;
          if (cfg_setup != '0) begin
            phase_d = PH_SETUP;
            cnt_val = cfg_setup - ONE;
          end else begin
            phase_d = PH_STROBE;
            cnt_val = strb_eff - ONE;
          end
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d  = PH_STROBE;
          cnt_load = 1'b1;
          cnt_val  = strb_q - ONE;
        end
      end
      PH_STROBE: begin
        if (!freeze && cnt_zero) begin
          if (hold_q != '0) begin
            phase_d  = PH_HOLD;
            cnt_load = 1'b1;
            cnt_val  = hold_q - ONE;
          end else begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (cnt_zero) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign cnt_dec = (phase_q != PH_IDLE) && !freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      strb_q <= ONE;
      hold_q <= '0;
    end else if (capture) begin
      addr_q <= req_addr;
      data_q <= req_data;
      strb_q <= strb_eff;
      hold_q <= cfg_hold;
    end
  end

  assign mem_cs_n = (phase_q == PH_IDLE);
  assign mem_we_n = (phase_q != PH_STROBE);
  assign mem_addr = addr_q;
  assign mem_data = data_q;
  assign req_done = done_q;

  // R8: a frozen edge leaves every bus output unchanged
  a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(mem_cs_n) && $stable(mem_we_n) &&
                $stable(mem_addr) && $stable(mem_data)));

  // R9: freezing only happens while the strobe is low
  a_r9_freeze_window: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (!mem_we_n && !mem_cs_n));

  // R6: done coincides with the first chip-select-high cycle and lasts one cycle
  a_r6_done_edge: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> (mem_cs_n && $past(!mem_cs_n)));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  // R10: a start during a write does not disturb the captured address
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && req_start) |=> $stable(mem_addr));
endmodule

// File: tb/sram_write_seq_tb.sv
module sram_write_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_start;
  logic [15:0] req_addr;
  logic [7:0]  req_data;
  logic [3:0]  cfg_setup, cfg_strobe, cfg_hold;
  logic        req_done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic        mem_cs_n, mem_we_n;
  logic        mem_wait_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  sram_write_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start),
    .req_addr(req_addr), .req_data(req_data),
    .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
    .req_done(req_done), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_wait_n(mem_wait_n)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One write; wait pin goes low after sample wait_at for wait_len samples.
  task automatic run_write(input logic [15:0] a, input logic [7:0] d,
                           input int su, input int st, input int ho,
                           input int wait_at, input int wait_len, input int extra,
                           input string tag, input bit poke);
    int cs_low = 0, we_low = 0, setup_n = 0, hold_n = 0;
    bit seen_we = 0, seen_done = 0, addr_ok = 1, done_cs_ok = 0;
    int st_eff = (st == 0) ? 1 : st;
    @(negedge clk);
    req_addr = a; req_data = d;
    cfg_setup = 4'(su); cfg_strobe = 4'(st); cfg_hold = 4'(ho);
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    for (int n = 0; n < 200 && !seen_done; n++) begin
      if (req_done) begin
        seen_done = 1;
        done_cs_ok = mem_cs_n;
      end else if (!mem_cs_n) begin
        cs_low++;
        if (mem_addr != a || mem_data != d) addr_ok = 0;
        if (!mem_we_n) begin we_low++; seen_we = 1; end
        else if (!seen_we) setup_n++;
        else hold_n++;
      end
      if (n == wait_at) mem_wait_n = 1'b0;
      if (n == wait_at + wait_len) mem_wait_n = 1'b1;
      if (poke && n == 1) begin
        req_start = 1'b1; req_addr = 16'hDEAD; req_data = 8'h5A;
        cfg_setup = 4'd15; cfg_strobe = 4'd15; cfg_hold = 4'd15;
      end
      if (poke && n == 2) req_start = 1'b0;
      if (!seen_done) @(negedge clk);
    end
    mem_wait_n = 1'b1;
    check(seen_done, "R6 done seen", int'(seen_done), 1);
    check(done_cs_ok, "R6 done with cs high", int'(done_cs_ok), 1);
    check(setup_n == su, {tag, " R2 setup cycles"}, setup_n, su);
    check(we_low == st_eff + extra, {tag, " R3/R7 strobe cycles"}, we_low, st_eff + extra);
    check(hold_n == ho, {tag, " R4 hold cycles"}, hold_n, ho);
    check(cs_low == su + st_eff + ho + extra, {tag, " R8 cs cycles"}, cs_low, su + st_eff + ho + extra);
    check(addr_ok, {tag, " R5 addr/data"}, int'(addr_ok), 1);
    @(negedge clk);
    check(!req_done, "R6 done single", int'(req_done), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_start = 1'b0; req_addr = '0; req_data = '0;
    cfg_setup = '0; cfg_strobe = '0; cfg_hold = '0; mem_wait_n = 1'b1;
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_we_n && !req_done, "R1 in reset", int'({mem_cs_n, mem_we_n, req_done}), 6);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mem_cs_n && mem_we_n && !req_done, "R1 after reset", int'({mem_cs_n, mem_we_n, req_done}), 6);
  endtask

  task automatic t_idle_quiet(input string tag);
    bit quiet = 1;
    for (int i = 0; i < 4; i++) begin
      if (!mem_cs_n || !mem_we_n || req_done) quiet = 0;
      @(negedge clk);
    end
    check(quiet, tag, int'(quiet), 1);
  endtask

  initial begin
    t_reset();
    run_write(16'h1234, 8'hA5, 1, 5, 1, -10, 0, 0, "basic", 0);
    run_write(16'h0F0F, 8'h3C, 0, 0, 0, -10, 0, 0, "R3 zero strobe", 0);
    run_write(16'hBEEF, 8'hC3, 3, 4, 2, -10, 0, 0, "mixed", 0);
    // R7: wait at first strobe sample, 3 cycles -> 3 frozen edges
    run_write(16'h4242, 8'h81, 1, 5, 1, 1, 3, 3, "R7 freeze", 0);
    // R9 boundary: latest strobe sample that still freezes (j = S-4)
    run_write(16'h4343, 8'h18, 1, 5, 1, 2, 2, 2, "R9 last window", 0);
    // R9: too late in strobe -> ignored
    run_write(16'h4444, 8'h99, 1, 5, 1, 3, 3, 0, "R9 late", 0);
    // R9: wait during setup -> ignored
    run_write(16'h5555, 8'h66, 6, 4, 1, 0, 2, 0, "R9 setup", 0);
    // R9: wait during hold -> ignored
    run_write(16'h6666, 8'h77, 0, 2, 4, 2, 2, 0, "R9 hold", 0);
    // R10 / R11: start and new config during a write are ignored
    run_write(16'h7777, 8'h11, 2, 3, 2, -10, 0, 0, "R10 R11 busy", 1);
    t_idle_quiet("R10 no second write");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule